// File: doc/BRIEF.md
# Decrement-and-Skip Execution Unit

This unit runs two conditional-skip instructions against an 8-bit banked data memory. Each instruction reads one file register, takes one from it and stores the result either in the working register (W) or back in the same file location. One opcode then skips the following instruction when the new value is zero. The other skips it when the new value is not zero. A skip tells the fetch stage to throw away the instruction it has already fetched, and the unit then runs one or two idle cycles in its place. It runs two idle cycles when the discarded instruction takes two program words.

An instruction cycle is four clocks: decode, read, process and write. The fetch stage offers a word with `issue` while the unit is idle, and it reports on `twoWordNext` whether the word after it is a two-word instruction. The unit raises `busy` until the last cycle ends and pulses `done` in that cycle's write phase. A loader port sets W, the bank register and the memory between instructions and reads the memory back. Storage is held for the low `IMPL_BANK_BITS` of the bank number only. Higher bank numbers alias onto these.

Top module: `dec_skip_unit`

## Requirements
- R1: An issued word is accepted only while idle, and only if bits 15:12 are 0010 (skip when zero) or 0100 (skip when not zero) and bits 11:10 are 11. Any other word, and any issue while busy, leaves every output and all stored state unchanged.
- R2: The stored result is the operand minus one, modulo 256, so 0x00 becomes 0xFF.
- R3: Bit 9 selects the destination. With 0 the result goes to W and the file location keeps its value. With 1 the result goes to the file location and W keeps its value.
- R4: Bit 8 selects the bank and bits 7:0 give the file offset. With bit 8 at 1 the bank is the bank register. With bit 8 at 0 the bank register is ignored: offsets 0x00-0x7F use bank 0 and offsets 0x80-0xFF use bank 15. The storage index is {bank mod 2^IMPL_BANK_BITS, offset}.
- R5: Opcode 0010 skips exactly when the result is zero. Opcode 0100 skips exactly when the result is non-zero.
- R6: The first clock after an accepted issue is phase 0. Phase then counts 0, 1, 2, 3 in every instruction cycle, and `busy` stays high until the last cycle ends.
- R7: When a skip occurs, `flush` pulses for one clock in phase 3 of the executing cycle. After it come one idle cycle (`twoWordNext` = 0 at issue) or two idle cycles (`twoWordNext` = 1), with `nopActive` high throughout. Idle cycles change no state.
- R8: `done` pulses for one clock in phase 3 of the final cycle. The whole instruction lasts 4, 8 or 12 clocks, and `busy` is low on the clock after `done`.
- R9: After reset W and the bank register are zero. While idle, the loader strobes write W, the bank register or the memory location at `hostAddr`. `hostRdata` returns the memory location at `hostAddr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Offers `instrWord` for execution |
| instrWord | input | 16 | Instruction word |
| twoWordNext | input | 1 | The prefetched next instruction is two words long |
| busy | output | 1 | An instruction is in progress |
| phase | output | 2 | Current phase 0..3 (decode, read, process, write) |
| nopActive | output | 1 | Current cycle is a forced idle cycle |
| flush | output | 1 | Discard the prefetched instruction |
| done | output | 1 | Final phase of the instruction |
| hostMemWe | input | 1 | Loader write strobe for the memory |
| hostAddr | input | IMPL_BANK_BITS+8 | Loader storage index |
| hostMemData | input | DATA_W | Loader write data |
| hostRdata | output | DATA_W | Memory contents at `hostAddr` |
| hostWWe | input | 1 | Loader write strobe for W |
| hostWData | input | DATA_W | Value to load into W |
| hostBsrWe | input | 1 | Loader write strobe for the bank register |
| hostBsrData | input | BANK_W | Value to load into the bank register |
| wReg | output | DATA_W | Working register |
| bsrReg | output | BANK_W | Bank register |

## Verification
Operands of 5, 1 and 0 are run through both opcodes. This separates an ordinary decrement from a result of zero and from the wrap to 0xFF, and it shows that the two skip polarities are opposite. Each case is run with single-word and with two-word followers, so the 4-, 8- and 12-clock timelines each appear on the flush and done pins. Direct-bank cases use offsets on both sides of 0x80 while the bank register holds a value that would hit a different location. This shows the register is ignored. A bank value above the stored range shows the aliasing, and repeated decrements of one counter show the loop exit. Malformed words and an issue made during execution must leave the timeline and all state alone.

// File: rtl/dskip_pkg.sv
package dskip_pkg;
  localparam int INSTR_W = 16;
  localparam int FILE_AW = 8;
  localparam logic [3:0] OP_SKIP_ZERO = 4'b0010;
  localparam logic [3:0] OP_SKIP_NZ   = 4'b0100;
  localparam logic [1:0] OP_TAIL      = 2'b11;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  // control-to-datapath strobes, one per active phase of an executing cycle
  typedef struct packed {
    logic latchAddr;
    logic latchOperand;
    logic latchResult;
    logic commit;
  } dpStrobe_t;

  // decoded fields held for the whole instruction
  typedef struct packed {
    logic               opNotZero;
    logic               dSel;
    logic               aSel;
    logic [FILE_AW-1:0] fAddr;
  } decoded_t;

  function automatic logic isLegal(input logic [INSTR_W-1:0] w);
    return ((w[15:12] == OP_SKIP_ZERO) || (w[15:12] == OP_SKIP_NZ)) && (w[11:10] == OP_TAIL);
  endfunction

  function automatic decoded_t decodeWord(input logic [INSTR_W-1:0] w);
    decoded_t d;
    d.opNotZero = (w[15:12] == OP_SKIP_NZ);
    d.dSel      = w[9];
    d.aSel      = w[8];
    d.fAddr     = w[FILE_AW-1:0];
    return d;
  endfunction
endpackage

// File: rtl/dskip_ctrl.sv
module dskip_ctrl
  import dskip_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               twoWordNext,
  input  logic               skipIn,
  output decoded_t           decoded,
  output dpStrobe_t          strobe,
  output logic               busy,
  output phase_e             phase,
  output logic               nopActive,
  output logic               flush,
  output logic               done
);
  logic     busyQ, inNopQ, nopMoreQ, twoWordQ;
  phase_e   phaseQ;
  decoded_t decodedQ;
  logic     accept, execCyc, lastPhase;

  assign accept    = !busyQ && issue && isLegal(instrWord);
  assign execCyc   = busyQ && !inNopQ;
  assign lastPhase = (phaseQ == PH_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ    <= 1'b0;
      phaseQ   <= PH_DECODE;
      inNopQ   <= 1'b0;
      nopMoreQ <= 1'b0;
      twoWordQ <= 1'b0;
      decodedQ <= '0;
    end else if (!busyQ) begin
      if (accept) begin
        busyQ    <= 1'b1;
        phaseQ   <= PH_DECODE;
        inNopQ   <= 1'b0;
        decodedQ <= decodeWord(instrWord);
        twoWordQ <= twoWordNext;
      end
    end else begin
      phaseQ <= phase_e'(phaseQ + 2'd1);
      if (lastPhase) begin
        if (!inNopQ) begin
          if (skipIn) begin
            inNopQ   <= 1'b1;
            nopMoreQ <= twoWordQ;
          end else begin
            busyQ <= 1'b0;
          end
        end else if (nopMoreQ) begin
          nopMoreQ <= 1'b0;
        end else begin
          inNopQ <= 1'b0;
          busyQ  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe.latchAddr    = execCyc && (phaseQ == PH_DECODE);
    strobe.latchOperand = execCyc && (phaseQ == PH_READ);
    strobe.latchResult  = execCyc && (phaseQ == PH_PROC);
    strobe.commit       = execCyc && lastPhase;
  end

  assign decoded   = decodedQ;
  assign busy      = busyQ;
  assign phase     = phaseQ;
  assign nopActive = busyQ && inNopQ;
  assign flush     = execCyc && lastPhase && skipIn;
  assign done      = busyQ && lastPhase && (inNopQ ? !nopMoreQ : !skipIn);

  // R1: a malformed word never starts an instruction
  p_illegal_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busyQ && issue && !isLegal(instrWord)) |=> !busyQ);

  // R6: phases advance by one while an instruction runs
  p_phase_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && phaseQ != PH_WRITE) |=> (busyQ && phaseQ == phase_e'($past(phaseQ) + 2'd1)));

  // R7: a flush is followed by the start of an idle cycle
  p_flush_then_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (nopActive && phase == PH_DECODE));

  // R8: the unit is idle after done
  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/dskip_dpath.sv
module dskip_dpath
  import dskip_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int BANK_W         = 4,
  parameter int IMPL_BANK_BITS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dpStrobe_t                         strobe,
  input  decoded_t                          decoded,
  output logic                              skipOut,
  input  logic                              hostMemWe,
  input  logic [IMPL_BANK_BITS+FILE_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]                 hostMemData,
  output logic [DATA_W-1:0]                 hostRdata,
  input  logic                              hostWWe,
  input  logic [DATA_W-1:0]                 hostWData,
  input  logic                              hostBsrWe,
  input  logic [BANK_W-1:0]                 hostBsrData,
  output logic [DATA_W-1:0]                 wReg,
  output logic [BANK_W-1:0]                 bsrReg
);
  localparam int PHYS_W = IMPL_BANK_BITS + FILE_AW;
  localparam int DEPTH  = 1 << PHYS_W;

  logic [DATA_W-1:0]         mem [DEPTH];
  logic [DATA_W-1:0]         wQ, operandQ, resultQ, decVal;
  logic [BANK_W-1:0]         bsrQ;
  logic [PHYS_W-1:0]         addrQ, effIdx;
  logic [IMPL_BANK_BITS-1:0] bankLow;
  logic                      skipQ, resultZero;

  // direct access: lower half of the offsets is bank 0, upper half bank all-ones
  assign bankLow    = decoded.aSel ? bsrQ[IMPL_BANK_BITS-1:0]
                                   : {IMPL_BANK_BITS{decoded.fAddr[FILE_AW-1]}};
  assign effIdx     = {bankLow, decoded.fAddr};
  assign decVal     = operandQ - DATA_W'(1);
  assign resultZero = (decVal == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ    <= '0;
      operandQ <= '0;
      resultQ  <= '0;
      skipQ    <= 1'b0;
      wQ       <= '0;
      bsrQ     <= '0;
    end else begin
      if (strobe.latchAddr)    addrQ    <= effIdx;
      if (strobe.latchOperand) operandQ <= mem[addrQ];
      if (strobe.latchResult) begin
        resultQ <= decVal;
        skipQ   <= resultZero ^ decoded.opNotZero;
      end
      if (strobe.commit && !decoded.dSel) wQ <= resultQ;
      else if (hostWWe)                   wQ <= hostWData;
      if (hostBsrWe) bsrQ <= hostBsrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit && decoded.dSel) mem[addrQ]    <= resultQ;
    else if (hostMemWe)                mem[hostAddr] <= hostMemData;
  end

  assign skipOut   = skipQ;
  assign hostRdata = mem[hostAddr];
  assign wReg      = wQ;
  assign bsrReg    = bsrQ;

  // R2: the result is one below the operand, modulo 2^DATA_W
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.latchResult) |-> (DATA_W'(resultQ + DATA_W'(1)) == operandQ));

  // R5: operand of one means a zero result; polarity flips with the opcode
  p_skip_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.latchResult) |-> (skipQ == ((operandQ == DATA_W'(1)) != decoded.opNotZero)));

  // R3: destination W receives the result
  p_w_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && !decoded.dSel) |=> (wQ == $past(resultQ)));

  // R3: destination file leaves W alone
  p_w_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && decoded.dSel && !hostWWe) |=> $stable(wQ));

  // R3: destination file receives the result
  p_file_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && decoded.dSel) |=> (mem[$past(addrQ)] == $past(resultQ)));
endmodule

// File: rtl/dec_skip_unit.sv
module dec_skip_unit
  import dskip_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int BANK_W         = 4,
  parameter int IMPL_BANK_BITS = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              issue,
  input  logic [15:0]                       instrWord,
  input  logic                              twoWordNext,
  output logic                              busy,
  output logic [1:0]                        phase,
  output logic                              nopActive,
  output logic                              flush,
  output logic                              done,
  input  logic                              hostMemWe,
  input  logic [IMPL_BANK_BITS+FILE_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]                 hostMemData,
  output logic [DATA_W-1:0]                 hostRdata,
  input  logic                              hostWWe,
  input  logic [DATA_W-1:0]                 hostWData,
  input  logic                              hostBsrWe,
  input  logic [BANK_W-1:0]                 hostBsrData,
  output logic [DATA_W-1:0]                 wReg,
  output logic [BANK_W-1:0]                 bsrReg
);
  dpStrobe_t strobe;
  decoded_t  decoded;
  phase_e    phaseState;
  logic      skip;

  dskip_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .instrWord   (instrWord),
    .twoWordNext (twoWordNext),
    .skipIn      (skip),
    .decoded     (decoded),
    .strobe      (strobe),
    .busy        (busy),
    .phase       (phaseState),
    .nopActive   (nopActive),
    .flush       (flush),
    .done        (done)
  );

  dskip_dpath #(
    .DATA_W         (DATA_W),
    .BANK_W         (BANK_W),
    .IMPL_BANK_BITS (IMPL_BANK_BITS)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .decoded     (decoded),
    .skipOut     (skip),
    .hostMemWe   (hostMemWe),
    .hostAddr    (hostAddr),
    .hostMemData (hostMemData),
    .hostRdata   (hostRdata),
    .hostWWe     (hostWWe),
    .hostWData   (hostWData),
    .hostBsrWe   (hostBsrWe),
    .hostBsrData (hostBsrData),
    .wReg        (wReg),
    .bsrReg      (bsrReg)
  );

  assign phase = phaseState;
endmodule

// File: tb/dec_skip_unit_bench.sv
module dec_skip_unit_bench;
  localparam int BANKS_KEPT = 4;
  localparam int IDX_W      = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [15:0] instrWord = '0;
  logic        twoWordNext = 1'b0;
  logic        busy, nopActive, flush, done;
  logic [1:0]  phase;
  logic        hostMemWe = 1'b0, hostWWe = 1'b0, hostBsrWe = 1'b0;
  logic [IDX_W-1:0] hostAddr = '0;
  logic [7:0]  hostMemData = '0, hostWData = '0, hostRdata, wReg;
  logic [3:0]  hostBsrData = '0, bsrReg;

  int vectors = 0;
  int misses  = 0;
  logic [7:0] modelMem [1 << IDX_W];
  logic [7:0] modelW   = 8'h00;
  logic [3:0] modelBsr = 4'h0;
  int expQ[$];

  always #10 clk = ~clk;

  dec_skip_unit u_dec_skip_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instrWord(instrWord),
    .twoWordNext(twoWordNext), .busy(busy), .phase(phase), .nopActive(nopActive),
    .flush(flush), .done(done), .hostMemWe(hostMemWe), .hostAddr(hostAddr),
    .hostMemData(hostMemData), .hostRdata(hostRdata), .hostWWe(hostWWe),
    .hostWData(hostWData), .hostBsrWe(hostBsrWe), .hostBsrData(hostBsrData),
    .wReg(wReg), .bsrReg(bsrReg)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic notZero, input logic d, input logic a, input logic [7:0] f);
    return {(notZero ? 4'b0100 : 4'b0010), 2'b11, d, a, f};
  endfunction

  function automatic int pins();
    return (int'(busy) << 5) | (int'(phase) << 3) | (int'(nopActive) << 2) | (int'(flush) << 1) | int'(done);
  endfunction

  task automatic loadMem(input int idx, input logic [7:0] v);
    @(negedge clk);
    hostMemWe = 1'b1; hostAddr = IDX_W'(idx); hostMemData = v;
    @(negedge clk);
    hostMemWe = 1'b0;
    modelMem[idx] = v;
  endtask

  task automatic loadBsr(input logic [3:0] v);
    @(negedge clk);
    hostBsrWe = 1'b1; hostBsrData = v;
    @(negedge clk);
    hostBsrWe = 1'b0;
    modelBsr = v;
  endtask

  task automatic loadW(input logic [7:0] v);
    @(negedge clk);
    hostWWe = 1'b1; hostWData = v;
    @(negedge clk);
    hostWWe = 1'b0;
    modelW = v;
  endtask

  task automatic checkMem(input string req, input int idx);
    hostAddr = IDX_W'(idx);
    #1;
    check(req, $sformatf("mem[%0h]", idx), int'(hostRdata), int'(modelMem[idx]));
  endtask

  // behavioural reference: builds the expected pin timeline, then updates the model
  task automatic runInstr(input logic [15:0] word, input logic two, input int pokeAt, input string req);
    logic legal;
    logic [3:0] bank;
    logic [7:0] op, res;
    logic skip;
    int idx, cycles;
    legal = ((word[15:12] == 4'b0010) || (word[15:12] == 4'b0100)) && (word[11:10] == 2'b11);
    idx = 0; res = 8'h00;
    expQ.delete();
    if (legal) begin
      bank   = word[8] ? modelBsr : (word[7] ? 4'hF : 4'h0);
      idx    = ((int'(bank) % BANKS_KEPT) << 8) | int'(word[7:0]);
      op     = modelMem[idx];
      res    = op - 8'd1;
      skip   = (word[15:12] == 4'b0010) ? (res == 8'h00) : (res != 8'h00);
      cycles = 1 + (skip ? (two ? 2 : 1) : 0);
      for (int c = 0; c < cycles; c++)
        for (int p = 0; p < 4; p++)
          expQ.push_back((1 << 5) | (p << 3) | (int'(c > 0) << 2) |
                         (int'(c == 0 && p == 3 && skip) << 1) | int'(p == 3 && c == cycles - 1));
    end
    expQ.push_back(0);
    @(negedge clk);
    issue = 1'b1; instrWord = word; twoWordNext = two;
    for (int k = 0; k < expQ.size(); k++) begin
      @(negedge clk);
      check(req, $sformatf("pins clk%0d", k), pins(), expQ[k]);
      issue = (k == pokeAt);
      if (k == pokeAt) begin
        instrWord = mk(1'b1, 1'b0, 1'b1, 8'h00);
        twoWordNext = 1'b1;
      end
    end
    issue = 1'b0;
    if (legal) begin
      if (word[9]) modelMem[idx] = res;
      else         modelW = res;
      checkMem({req, " R3"}, idx);
    end
    check({req, " R3"}, "W", int'(wReg), int'(modelW));
    check("R9", "bank reg", int'(bsrReg), int'(modelBsr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset busy", int'(busy), 0);
    check("R9", "reset W", int'(wReg), 0);
    check("R9", "reset bank", int'(bsrReg), 0);
    check("R8", "reset done/flush", int'({done, flush}), 0);
    rst_n = 1'b1;
    // clear storage through the loader
    @(negedge clk);
    hostMemWe = 1'b1; hostMemData = 8'h00;
    for (int i = 0; i < (1 << IDX_W); i++) begin
      hostAddr = IDX_W'(i);
      modelMem[i] = 8'h00;
      @(negedge clk);
    end
    hostMemWe = 1'b0;
    loadBsr(4'h2);
    loadW(8'hAA);
    loadMem(12'h210, 8'h05);
    checkMem("R9", 12'h210);
    check("R9", "W load", int'(wReg), 8'hAA);
    // R2: plain decrement, file destination, no skip: 4 clocks
    runInstr(mk(1'b0, 1'b1, 1'b1, 8'h10), 1'b0, -1, "R2");
    // R5 R7: zero result skips, W destination, single-word follower: 8 clocks
    loadMem(12'h211, 8'h01);
    runInstr(mk(1'b0, 1'b0, 1'b1, 8'h11), 1'b0, -1, "R5");
    // R7 R8: two-word follower, 12 clocks
    loadMem(12'h212, 8'h01);
    runInstr(mk(1'b0, 1'b1, 1'b1, 8'h12), 1'b1, -1, "R7");
    // R2: 0x00 wraps to 0xFF, zero-skip does not skip
    loadMem(12'h213, 8'h00);
    runInstr(mk(1'b0, 1'b1, 1'b1, 8'h13), 1'b1, -1, "R2");
    // R5: wrap with the not-zero opcode does skip
    loadMem(12'h214, 8'h00);
    runInstr(mk(1'b1, 1'b1, 1'b1, 8'h14), 1'b1, -1, "R5");
    // R5: not-zero opcode with zero result, no skip
    loadMem(12'h215, 8'h01);
    runInstr(mk(1'b1, 1'b1, 1'b1, 8'h15), 1'b0, -1, "R5");
    // R4: direct low half ignores bank register (bank 2 holds a decoy)
    loadMem(12'h020, 8'h09);
    loadMem(12'h220, 8'h33);
    runInstr(mk(1'b1, 1'b0, 1'b0, 8'h20), 1'b0, -1, "R4");
    checkMem("R4", 12'h220);
    // R4: direct high half maps to bank 15 (kept as storage bank 3)
    loadBsr(4'h1);
    loadMem(12'h385, 8'h40);
    loadMem(12'h185, 8'h77);
    runInstr(mk(1'b0, 1'b1, 1'b0, 8'h85), 1'b0, -1, "R4");
    checkMem("R4", 12'h185);
    // R1: malformed words change nothing
    runInstr(16'h3F10, 1'b0, -1, "R1");
    runInstr(16'h2A10, 1'b1, -1, "R1");
    checkMem("R1", 12'h210);
    // R1: issue during execution is ignored
    loadMem(12'h216, 8'h07);
    runInstr(mk(1'b0, 1'b1, 1'b1, 8'h16), 1'b0, 1, "R1");
    // R6 R4: counting loop in bank 5, kept as storage bank 1, exits on third pass
    loadBsr(4'h5);
    loadMem(12'h130, 8'h03);
    for (int n = 0; n < 3; n++)
      runInstr(mk(1'b0, 1'b1, 1'b1, 8'h30), 1'b0, -1, "R6");
    check("R6", "loop counter", int'(modelMem[12'h130]), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule